// File: doc/BRIEF.md
# Compare-Branch and Arithmetic Execute Unit

This unit is the execute stage of a small command sequencer. Each issued instruction arrives as an 8-bit opcode with three 32-bit operand fields. Three bits of the opcode state, one per operand, whether that operand's field is used directly as an immediate or address, or names a register whose contents are used. The unit holds its own register file, program counter and multiply overflow register. In a single cycle it resolves signed compare-and-branch, zero-test branches, unconditional jumps, integer add, subtract, multiply and divide, and increment and decrement.

Results leave the unit through a one-cycle register write-back report. The next program counter and a one-cycle illegal-opcode flag are also presented, all registered one clock after the instruction is issued. A register written by one instruction is visible as a register operand to the very next instruction.

Top module: `seq_exec_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, the PC, the overflow register and every register hold 0, and the write-back and illegal outputs are low.
- R2: Opcode bit 3, bit 2 and bit 1 select the source of operands 1, 2 and 3. A set bit means the operand field itself is used. A clear bit means the operand's value is the register whose index is the low 4 bits of the field.
- R3: ADD (upper nibble 0) and SUB (upper nibble 1), with bit 0 set and bit 3 clear, write operand 2 plus or minus operand 3, modulo 2^32, to the register indexed by operand 1's field. wb_valid, wb_idx and wb_data report the write in the cycle after issue, and wb_idx and wb_data are 0 whenever wb_valid is low.
- R4: MUL (upper nibble 2, bit 0 set, bit 3 clear) forms the signed 64-bit product. The low word goes to the register indexed by operand 1 and the high word to the overflow register. No other instruction changes the overflow register.
- R5: DIV (upper nibble 3, bit 0 set, bit 3 clear) writes the signed quotient truncated toward zero. A zero divisor yields 0, and 0x80000000 divided by -1 yields 0x80000000.
- R6: With bit 0 and bit 2 clear, upper nibbles 0 to 5 compare operand 2 (a register) with operand 3 as signed values, for equal, not equal, less, less-or-equal, greater and greater-or-equal. When the comparison holds, the next PC is the low PC bits of operand 1.
- R7: Opcodes 0x90/0x98 branch to operand 1 when register operand 2 is zero. Opcodes 0x82/0x8A branch when it is non-zero. Opcodes 0xC2/0xCA jump to operand 1 unconditionally.
- R8: Opcode 0xC6 adds 1 to, and opcode 0xD0 subtracts 1 from, the register indexed by operand 1, modulo 2^32.
- R9: Any issued instruction that does not take a branch advances the PC by one, modulo 2^PC_W.
- R10: Every other opcode raises illegal for exactly one cycle, writes nothing and advances the PC by one. This includes nibbles 6 and 7, arithmetic codes with bit 3 set, and branch codes with bit 2 set.
- R11: In a cycle without issue_valid, the PC, the registers and the overflow register keep their values, and wb_valid and illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction code with operand-source bits |
| opnd1 | input | DATA_W | Operand 1 field (destination, target or value) |
| opnd2 | input | DATA_W | Operand 2 field |
| opnd3 | input | DATA_W | Operand 3 field |
| pc | output | PC_W | Program counter after the last issued instruction |
| wb_valid | output | 1 | A register was written by the last instruction |
| wb_idx | output | IDX_W | Index of the written register |
| wb_data | output | DATA_W | Value written |
| illegal | output | 1 | Last instruction had an unassigned opcode |
| ovf_reg | output | DATA_W | High word of the most recent product |

## Verification
The bench builds the unit with DATA_W 32, 16 registers and PC_W 8. The narrow PC lets a run of ordinary instructions carry the counter through its wrap from 255 to 0, and shows that branch targets wider than the PC are truncated. With 32-bit data, the signed corners are reached directly: a negative product filling the overflow word, the most-negative dividend over -1, and the wrap of increment and decrement.

// File: rtl/seq_exec_pkg.sv
package seq_exec_pkg;

    typedef enum logic [2:0] {
        K_ILL,
        K_ALU,
        K_BR3,
        K_BZ,
        K_BNZ,
        K_JMP,
        K_INC,
        K_DEC
    } kind_e;

    localparam logic [1:0] AOP_ADD = 2'd0;
    localparam logic [1:0] AOP_SUB = 2'd1;
    localparam logic [1:0] AOP_MUL = 2'd2;
    localparam logic [1:0] AOP_DIV = 2'd3;

    typedef struct packed {
        kind_e      kind;
        logic       imm1;
        logic       imm2;
        logic       imm3;
        logic [2:0] cond;
        logic [1:0] aop;
    } dec_t;

endpackage

// File: rtl/seq_exec_decode.sv
module seq_exec_decode
    import seq_exec_pkg::*;
(
    input  logic [7:0] op,
    output dec_t       dec
);
    always_comb begin
        dec.imm1 = op[3];
        dec.imm2 = op[2];
        dec.imm3 = op[1];
        dec.cond = op[6:4];
        dec.aop  = op[5:4];
        casez (op)
            8'b00??_?0?0,
            8'b010?_?0?0: dec.kind = K_BR3;
            8'b00??_0??1: dec.kind = K_ALU;
            8'b1001_?000: dec.kind = K_BZ;
            8'b1000_?010: dec.kind = K_BNZ;
            8'b1100_?010: dec.kind = K_JMP;
            8'b1100_0110: dec.kind = K_INC;
            8'b1101_0000: dec.kind = K_DEC;
            default:      dec.kind = K_ILL;
        endcase
    end
endmodule

// File: rtl/seq_exec_alu.sv
module seq_exec_alu
    import seq_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        aop,
    input  logic [2:0]        cond,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] hi,
    output logic              cond_met
);
    localparam int PROD_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MINUS_ONE = '1;

    logic [PROD_W-1:0] prod;
    logic              lt_s;

    always_comb begin
        prod = {{DATA_W{a[DATA_W-1]}}, a} * {{DATA_W{b[DATA_W-1]}}, b};
        hi   = prod[PROD_W-1:DATA_W];
        unique case (aop)
            AOP_ADD: res = a + b;
            AOP_SUB: res = a - b;
            AOP_MUL: res = prod[DATA_W-1:0];
            default: begin
                if (b == '0)
                    res = '0;
                else if (a == MOST_NEG && b == MINUS_ONE)
                    res = MOST_NEG;
                else
                    res = DATA_W'($signed(a) / $signed(b));
            end
        endcase
    end

    always_comb begin
        lt_s = $signed(a) < $signed(b);
        case (cond)
            3'd0:    cond_met = (a == b);
            3'd1:    cond_met = (a != b);
            3'd2:    cond_met = lt_s;
            3'd3:    cond_met = lt_s || (a == b);
            3'd4:    cond_met = !lt_s && (a != b);
            3'd5:    cond_met = !lt_s;
            default: cond_met = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq_exec_regfile.sv
module seq_exec_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra1,
    input  logic [IDX_W-1:0]  ra2,
    input  logic [IDX_W-1:0]  ra3,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2,
    output logic [DATA_W-1:0] rd3
);
    logic [DATA_W-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DATA_W-1:0] reg_d;

        always_comb begin
            reg_d = regs_q[g];
            if (we && widx == IDX_W'(g))
                reg_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else
                regs_q[g] <= reg_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
    assign rd3 = regs_q[ra3];
endmodule

// File: rtl/seq_exec_unit.sv
module seq_exec_unit
    import seq_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    parameter int PC_W   = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] opnd1,
    input  logic [DATA_W-1:0] opnd2,
    input  logic [DATA_W-1:0] opnd3,
    output logic [PC_W-1:0]   pc,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              illegal,
    output logic [DATA_W-1:0] ovf_reg
);
    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              wbv;
        logic [IDX_W-1:0]  wbi;
        logic [DATA_W-1:0] wbd;
        logic              ill;
        logic [DATA_W-1:0] ovf;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic [DATA_W-1:0] rd1, rd2, rd3;
    logic [DATA_W-1:0] v1, v2, v3;
    logic [DATA_W-1:0] alu_res, alu_hi;
    logic              cond_met;

    seq_exec_decode u_dec (
        .op  (opcode),
        .dec (dec)
    );

    seq_exec_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NREGS)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_d.wbv),
        .widx  (st_d.wbi),
        .wdata (st_d.wbd),
        .ra1   (opnd1[IDX_W-1:0]),
        .ra2   (opnd2[IDX_W-1:0]),
        .ra3   (opnd3[IDX_W-1:0]),
        .rd1   (rd1),
        .rd2   (rd2),
        .rd3   (rd3)
    );

    assign v1 = dec.imm1 ? opnd1 : rd1;
    assign v2 = dec.imm2 ? opnd2 : rd2;
    assign v3 = dec.imm3 ? opnd3 : rd3;

    seq_exec_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a        (v2),
        .b        (v3),
        .aop      (dec.aop),
        .cond     (dec.cond),
        .res      (alu_res),
        .hi       (alu_hi),
        .cond_met (cond_met)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wbv = 1'b0;
        st_d.wbi = '0;
        st_d.wbd = '0;
        st_d.ill = 1'b0;
        if (issue_valid) begin
            st_d.pc = st_q.pc + PC_W'(1);
            case (dec.kind)
                K_ALU: begin
                    st_d.wbv = 1'b1;
                    st_d.wbi = opnd1[IDX_W-1:0];
                    st_d.wbd = alu_res;
                    if (dec.aop == AOP_MUL)
                        st_d.ovf = alu_hi;
                end
                K_BR3: if (cond_met) st_d.pc = v1[PC_W-1:0];
                K_BZ:  if (v2 == '0) st_d.pc = v1[PC_W-1:0];
                K_BNZ: if (v2 != '0) st_d.pc = v1[PC_W-1:0];
                K_JMP: st_d.pc = v1[PC_W-1:0];
                K_INC: begin
                    st_d.wbv = 1'b1;
                    st_d.wbi = opnd1[IDX_W-1:0];
                    st_d.wbd = rd1 + DATA_W'(1);
                end
                K_DEC: begin
                    st_d.wbv = 1'b1;
                    st_d.wbi = opnd1[IDX_W-1:0];
                    st_d.wbd = rd1 - DATA_W'(1);
                end
                default: st_d.ill = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pc       = st_q.pc;
    assign wb_valid = st_q.wbv;
    assign wb_idx   = st_q.wbi;
    assign wb_data  = st_q.wbd;
    assign illegal  = st_q.ill;
    assign ovf_reg  = st_q.ovf;
endmodule

// File: rtl/seq_exec_chk.sv
module seq_exec_chk #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    parameter int PC_W   = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] opnd1,
    input logic [DATA_W-1:0] opnd3,
    input logic [PC_W-1:0]   pc,
    input logic              wb_valid,
    input logic [IDX_W-1:0]  wb_idx,
    input logic [DATA_W-1:0] wb_data,
    input logic              illegal,
    input logic [DATA_W-1:0] ovf_reg
);
    logic is_mul, is_div_imm0;
    assign is_mul      = opcode[7:4] == 4'h2 && opcode[0] && !opcode[3];
    assign is_div_imm0 = opcode[7:4] == 4'h3 && opcode[0] && !opcode[3]
                         && opcode[1] && opnd3 == '0;

    // R10
    ill_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wb_valid);

    // R10
    ill_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> pc == PC_W'($past(pc) + PC_W'(1)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(pc) && $stable(ovf_reg) && !wb_valid && !illegal);

    // R3
    wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> wb_idx == '0 && wb_data == '0);

    // R4
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !is_mul |=> $stable(ovf_reg));

    // R5
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && is_div_imm0 |=> wb_valid && wb_data == '0);

    // R7
    jmp_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && opcode == 8'hCA |=> pc == $past(opnd1[PC_W-1:0]) && !wb_valid);
endmodule

bind seq_exec_unit seq_exec_chk #(
    .DATA_W (DATA_W),
    .NREGS  (NREGS),
    .PC_W   (PC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .opcode      (opcode),
    .opnd1       (opnd1),
    .opnd3       (opnd3),
    .pc          (pc),
    .wb_valid    (wb_valid),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data),
    .illegal     (illegal),
    .ovf_reg     (ovf_reg)
);

// File: tb/seq_exec_unit_bench.sv
module seq_exec_unit_bench;
    localparam int DW = 32;
    localparam int NR = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [7:0]    opcode = 8'h00;
    logic [DW-1:0] opnd1 = '0, opnd2 = '0, opnd3 = '0;
    logic [PW-1:0] pc;
    logic          wb_valid;
    logic [3:0]    wb_idx;
    logic [DW-1:0] wb_data;
    logic          illegal;
    logic [DW-1:0] ovf_reg;

    seq_exec_unit #(.DATA_W(DW), .NREGS(NR), .PC_W(PW)) u_seq_exec_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .opnd1(opnd1), .opnd2(opnd2), .opnd3(opnd3), .pc(pc),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .illegal(illegal), .ovf_reg(ovf_reg)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [DW-1:0] m_regs [NR];
    logic [DW-1:0] m_ovf;
    logic [PW-1:0] m_pc;
    logic          m_wbv, m_ill;
    logic [3:0]    m_wbi;
    logic [DW-1:0] m_wbd;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "pc", 64'(pc), 64'(m_pc));
        chk(tag, "wb", {31'd0, wb_valid, 28'd0, wb_idx}, {31'd0, m_wbv, 28'd0, m_wbi});
        chk(tag, "wb_data", 64'(wb_data), 64'(m_wbd));
        chk(tag, "illegal", 64'(illegal), 64'(m_ill));
        chk(tag, "ovf", 64'(ovf_reg), 64'(m_ovf));
    endtask

    function automatic logic [DW-1:0] pick(input logic imm, input logic [DW-1:0] f);
        return imm ? f : m_regs[f[3:0]];
    endfunction

    task automatic model(input logic v, input logic [7:0] op,
                         input logic [DW-1:0] a, b, c);
        logic [DW-1:0] x1, x2, x3, r;
        logic [63:0]   p;
        logic          t;
        int            hi;
        m_wbv = 0; m_wbi = 0; m_wbd = 0; m_ill = 0;
        if (!v) return;
        hi = int'(op[7:4]);
        x1 = pick(op[3], a);
        x2 = pick(op[2], b);
        x3 = pick(op[1], c);
        m_pc = m_pc + 1;
        if (hi <= 5 && !op[0] && !op[2]) begin
            case (hi)
                0: t = x2 == x3;
                1: t = x2 != x3;
                2: t = $signed(x2) < $signed(x3);
                3: t = $signed(x2) <= $signed(x3);
                4: t = $signed(x2) > $signed(x3);
                default: t = $signed(x2) >= $signed(x3);
            endcase
            if (t) m_pc = x1[PW-1:0];
        end else if (hi <= 3 && op[0] && !op[3]) begin
            case (hi)
                0: r = x2 + x3;
                1: r = x2 - x3;
                2: begin
                    p = 64'($signed(x2)) * 64'($signed(x3));
                    r = p[31:0];
                    m_ovf = p[63:32];
                end
                default: begin
                    if (x3 == 0) r = 0;
                    else if (x2 == 32'h8000_0000 && x3 == 32'hFFFF_FFFF) r = x2;
                    else r = $signed(x2) / $signed(x3);
                end
            endcase
            m_regs[a[3:0]] = r;
            m_wbv = 1; m_wbi = a[3:0]; m_wbd = r;
        end else if (op == 8'h90 || op == 8'h98) begin
            if (x2 == 0) m_pc = x1[PW-1:0];
        end else if (op == 8'h82 || op == 8'h8A) begin
            if (x2 != 0) m_pc = x1[PW-1:0];
        end else if (op == 8'hC2 || op == 8'hCA) begin
            m_pc = x1[PW-1:0];
        end else if (op == 8'hC6 || op == 8'hD0) begin
            r = (op == 8'hC6) ? m_regs[a[3:0]] + 1 : m_regs[a[3:0]] - 1;
            m_regs[a[3:0]] = r;
            m_wbv = 1; m_wbi = a[3:0]; m_wbd = r;
        end else begin
            m_ill = 1;
        end
    endtask

    task automatic step(input logic v, input logic [7:0] op,
                        input logic [DW-1:0] a, b, c, input string tag);
        @(negedge clk);
        issue_valid = v; opcode = op; opnd1 = a; opnd2 = b; opnd3 = c;
        model(v, op, a, b, c);
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    // ADD rd = imm + imm : loads a register
    task automatic load(input int rd, input logic [DW-1:0] val, input string tag);
        step(1, 8'h07, DW'(rd), val, 0, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) m_regs[i] = 0;
        m_ovf = 0; m_pc = 0; m_wbv = 0; m_wbi = 0; m_wbd = 0; m_ill = 0;
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1;
        step(0, 8'h00, 0, 0, 0, "R1");
        for (int i = 0; i < NR; i++) step(1, 8'h03, DW'(i), DW'(i), 0, "R1");

        // R2 operand sources
        step(1, 8'h07, 1, 100, 23, "R2");
        step(1, 8'h01, 2, 1, 1, "R2");
        step(1, 8'h05, 3, 1000, 2, "R2");
        step(1, 8'h03, 4, 3, 32'hFFFF_FF05, "R2");

        // R3 add / sub
        step(1, 8'h17, 5, 5, 9, "R3");
        step(1, 8'h07, 6, 32'h7FFF_FFFF, 1, "R3");
        step(1, 8'h11, 7, 2, 5, "R3");

        // R4 multiply
        step(1, 8'h27, 8, 32'hFFFF_FFFD, 7, "R4");
        step(1, 8'h07, 9, 1, 1, "R4");
        step(1, 8'h27, 8, 32'h0001_0000, 32'h0001_0000, "R4");
        step(1, 8'h23, 10, 1, 32'h0000_0003, "R4");
        step(1, 8'h17, 9, 0, 0, "R4");

        // R5 divide
        step(1, 8'h37, 11, 32'hFFFF_FFF9, 2, "R5");
        step(1, 8'h37, 11, 1234, 0, "R5");
        step(1, 8'h37, 11, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
        step(1, 8'h37, 11, 100, 32'hFFFF_FFF9, "R5");
        load(12, 0, "R5");
        step(1, 8'h35, 11, 77, 12, "R5");

        // R6 three-operand branches
        for (int hi = 0; hi < 6; hi++) begin
            for (int k = 0; k < 3; k++) begin
                logic [DW-1:0] lhs, rhs;
                lhs = (k == 1) ? 9 : 32'hFFFF_FFFB;
                rhs = (k == 0) ? 9 : ((k == 1) ? 32'hFFFF_FFFB : 32'hFFFF_FFFB);
                load(13, lhs, "R6");
                step(1, {4'(hi), 4'b1010}, DW'(32'h1_00 + 40 + hi * 3 + k), 13, rhs, "R6");
                load(14, DW'(200 + k), "R6");
                load(15, rhs, "R6");
                step(1, {4'(hi), 4'b0000}, 14, 13, 15, "R6");
            end
        end

        // R7 zero tests and jumps
        load(1, 0, "R7");
        load(2, 5, "R7");
        step(1, 8'h98, 50, 1, 0, "R7");
        step(1, 8'h98, 60, 2, 0, "R7");
        step(1, 8'h8A, 70, 2, 0, "R7");
        step(1, 8'h8A, 80, 1, 0, "R7");
        step(1, 8'h90, 2, 1, 0, "R7");
        step(1, 8'h82, 2, 1, 0, "R7");
        step(1, 8'hCA, 32'hABCD_0033, 0, 0, "R7");
        step(1, 8'hC2, 2, 0, 0, "R7");

        // R8 increment / decrement with wrap
        load(3, 32'hFFFF_FFFF, "R8");
        step(1, 8'hC6, 3, 0, 0, "R8");
        step(1, 8'hD0, 3, 0, 0, "R8");
        step(1, 8'hD0, 4, 0, 0, "R8");
        step(1, 8'hC6, 4, 0, 0, "R8");

        // R9 PC wraps around 2^PW
        for (int i = 0; i < 300; i++) step(1, 8'h03, 5, 5, 1, "R9");

        // R10 unassigned codes
        begin
            logic [7:0] bad [12] = '{8'h60, 8'h70, 8'h41, 8'h0C, 8'h09, 8'hE0,
                                     8'hFF, 8'hB0, 8'hC0, 8'h92, 8'h51, 8'hCE};
            foreach (bad[i]) begin
                step(1, bad[i], 5, 5, 5, "R10");
                step(1, 8'h03, 5, 5, 0, "R10");
            end
        end

        // R11 idle cycles with noise on the inputs
        for (int i = 0; i < 10; i++) step(0, 8'h27, 5, 32'h1234, 32'h99, "R11");
        step(1, 8'h03, 5, 5, 0, "R11");

        // mixed stream
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] op;
            logic [DW-1:0] a, b, c;
            op = 8'($urandom);
            a = ($urandom % 2) ? DW'($urandom % 16) : DW'($urandom);
            b = ($urandom % 2) ? DW'($urandom % 16) : DW'($urandom);
            c = ($urandom % 4 == 0) ? 0 : DW'($urandom);
            step($urandom % 8 != 0, op, a, b, c, "R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule